// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM with Overlap Detection

This block is a synchronous memory with two access ports that share one clock and one storage array but present it at different widths. Port A moves whole 16-bit words; port B moves 4-bit nibbles. A nibble address on port B is the word address shifted left by two, with the two low bits choosing the nibble inside the word. Each port has an enable, a write strobe, an address, write data and a registered read output.

Alongside the storage sits a same-cycle overlap detector. It maps port B's nibble address back to a word address. When both ports are enabled on the same word and at least one of them writes, it raises a one-cycle flag. When only one port writes a shared location, the other port's read returns the contents from before that write. Each port's own write can return either the old contents or the newly written data, chosen per port by a parameter.

Top module: `asym_dp_ram`

## Requirements
- R1: While `rst_n` is low, `a_rdata`, `b_rdata` and `clash` are all zero.
- R2: An enabled read on port A returns the full word at `a_addr` on `a_rdata` one clock after the read.
- R3: Port B address `b_addr` names word `b_addr >> 2`, and nibble `b_addr[1:0]` of that word. Nibble 0 is bits [3:0] and nibble 3 is bits [15:12]. Reads and writes on port B use this packing.
- R4: If one port writes a word and the other port reads an overlapping location in the same cycle, the reading port returns the contents from before the write.
- R5: A port whose write-first parameter is 1 returns its own write data on its read output one clock after a write; a port whose parameter is 0 returns the old contents. The defaults are A read-first (`A_WRITE_FIRST=0`) and B write-first (`B_WRITE_FIRST=1`).
- R6: When both ports write overlapping locations in the same cycle, port A's data is stored in the shared nibble.
- R7: `clash` is high for one clock, in the cycle after a cycle in which both ports are enabled, at least one writes, and `b_addr >> 2` equals `a_addr`.
- R8: `clash` stays low after a cycle in which either port is disabled, in which neither port writes, or in which the ports touch different words.
- R9: A disabled port keeps its read output unchanged, and its write strobe has no effect on the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the outputs |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | A_AW (6) | Port A word address |
| a_wdata | input | WIDE_W (16) | Port A write data |
| a_rdata | output | WIDE_W (16) | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | B_AW (8) | Port B nibble address |
| b_wdata | input | NARROW_W (4) | Port B write data |
| b_rdata | output | NARROW_W (4) | Port B registered read data |
| clash | output | 1 | Registered overlap flag |

## Verification
The assertions assume that every port input is a known value at each rising edge while reset is released. They also assume that reset is held long enough to clear the outputs before the first access. The stimulus drives all inputs on the falling edge from known constants, holds reset for several cycles at the start, and reads only locations that an earlier row of the table has written. That last rule keeps every expected value defined. The disabled-port rows still drive a write strobe and data, so the hold and ignore checks face real stimulus.

// File: rtl/asym_dp_ram.sv
module asym_dp_ram #(
  parameter int WIDE_W        = 16,
  parameter int NARROW_W      = 4,
  parameter int WORDS         = 64,
  parameter bit A_WRITE_FIRST = 1'b0,
  parameter bit B_WRITE_FIRST = 1'b1,
  localparam int RATIO = WIDE_W / NARROW_W,
  localparam int SEL_W = $clog2(RATIO),
  localparam int A_AW  = $clog2(WORDS),
  localparam int B_AW  = A_AW + SEL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_en,
  input  logic                a_we,
  input  logic [A_AW-1:0]     a_addr,
  input  logic [WIDE_W-1:0]   a_wdata,
  output logic [WIDE_W-1:0]   a_rdata,
  input  logic                b_en,
  input  logic                b_we,
  input  logic [B_AW-1:0]     b_addr,
  input  logic [NARROW_W-1:0] b_wdata,
  output logic [NARROW_W-1:0] b_rdata,
  output logic                clash
);

  logic [WIDE_W-1:0] mem [WORDS];

  wire [A_AW-1:0]  b_word  = b_addr[B_AW-1:SEL_W];
  wire [SEL_W-1:0] b_sel   = b_addr[SEL_W-1:0];
  wire             a_wr    = a_en & a_we;
  wire             b_wr    = b_en & b_we;
  wire             overlap = (b_word == a_addr);
  wire             hit     = a_en & b_en & (a_we | b_we) & overlap;

  // port A is written last so it wins on a shared nibble
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_word][b_sel*NARROW_W +: NARROW_W] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
      clash   <= 1'b0;
    end else begin
      if (a_en)
        a_rdata <= (A_WRITE_FIRST && a_we) ? a_wdata : mem[a_addr];
      if (b_en)
        b_rdata <= (B_WRITE_FIRST && b_we) ? b_wdata
                                           : mem[b_word][b_sel*NARROW_W +: NARROW_W];
      clash <= hit;
    end
  end

endmodule

module asym_dp_ram_chk #(
  parameter int A_AW          = 6,
  parameter int B_AW          = 8,
  parameter int SEL_W         = 2,
  parameter int WIDE_W        = 16,
  parameter int NARROW_W      = 4,
  parameter bit B_WRITE_FIRST = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                a_en,
  input logic                a_we,
  input logic [A_AW-1:0]     a_addr,
  input logic [WIDE_W-1:0]   a_rdata,
  input logic                b_en,
  input logic                b_we,
  input logic [B_AW-1:0]     b_addr,
  input logic [NARROW_W-1:0] b_wdata,
  input logic [NARROW_W-1:0] b_rdata,
  input logic                clash
);

  // R7
  clash_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && b_en && (a_we || b_we) && (b_addr[B_AW-1:SEL_W] == a_addr)) |=> clash);

  // R8
  clash_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en && b_en) |=> !clash);

  // R8
  clash_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_we && !b_we) |=> !clash);

  // R9
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_rdata));

  // R9
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_rdata));

  // R5
  b_own_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (B_WRITE_FIRST && b_en && b_we) |=> (b_rdata == $past(b_wdata)));

endmodule

bind asym_dp_ram asym_dp_ram_chk #(
  .A_AW(A_AW), .B_AW(B_AW), .SEL_W(SEL_W),
  .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .B_WRITE_FIRST(B_WRITE_FIRST)
) chk (
  .clk(clk), .rst_n(rst_n),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_rdata(a_rdata),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
  .clash(clash)
);

// File: tb/asym_dp_ram_test.sv
module asym_dp_ram_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
  logic [5:0]  a_addr = '0;
  logic [15:0] a_wdata = '0;
  logic [7:0]  b_addr = '0;
  logic [3:0]  b_wdata = '0;
  logic [15:0] a_rdata;
  logic [3:0]  b_rdata;
  logic        clash;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asym_dp_ram uut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .clash(clash)
  );

  // {ae, awe, aaddr, awdata, be, bwe, baddr, bwdata, exp_a, exp_b, exp_clash, chk_a, chk_b}
  localparam int N = 16;
  localparam logic [60:0] TBL [N] = '{
    {1'b1,1'b1,6'd3,16'h1234, 1'b0,1'b0,8'd0 ,4'h0, 16'h0000,4'h0,1'b0, 1'b0,1'b1},
    {1'b1,1'b1,6'd5,16'hABCD, 1'b1,1'b1,8'd8 ,4'h7, 16'h0000,4'h7,1'b0, 1'b0,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b1,1'b0,8'd13,4'h0, 16'h1234,4'h3,1'b0, 1'b1,1'b1},
    {1'b1,1'b0,6'd5,16'h0000, 1'b1,1'b0,8'd23,4'h0, 16'hABCD,4'hA,1'b0, 1'b1,1'b1},
    {1'b1,1'b1,6'd3,16'h5678, 1'b1,1'b0,8'd12,4'h0, 16'h1234,4'h4,1'b1, 1'b1,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b0,1'b1,8'd12,4'hF, 16'h5678,4'h4,1'b0, 1'b1,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b1,1'b0,8'd12,4'h0, 16'h5678,4'h8,1'b0, 1'b1,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b1,1'b1,8'd14,4'h0, 16'h5678,4'h0,1'b1, 1'b1,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b0,1'b0,8'd0 ,4'h0, 16'h5078,4'h0,1'b0, 1'b1,1'b1},
    {1'b1,1'b1,6'd3,16'h9999, 1'b1,1'b1,8'd15,4'h1, 16'h5078,4'h1,1'b1, 1'b1,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b1,1'b0,8'd15,4'h0, 16'h9999,4'h9,1'b0, 1'b1,1'b1},
    {1'b0,1'b1,6'd3,16'h0000, 1'b1,1'b1,8'd9 ,4'hC, 16'h9999,4'hC,1'b0, 1'b1,1'b1},
    {1'b1,1'b0,6'd3,16'h0000, 1'b1,1'b0,8'd8 ,4'h0, 16'h9999,4'h7,1'b0, 1'b1,1'b1},
    {1'b1,1'b1,6'd2,16'h4321, 1'b1,1'b1,8'd20,4'hE, 16'h0000,4'hE,1'b0, 1'b0,1'b1},
    {1'b1,1'b0,6'd2,16'h0000, 1'b1,1'b0,8'd9 ,4'h0, 16'h4321,4'h2,1'b0, 1'b1,1'b1},
    {1'b1,1'b0,6'd5,16'h0000, 1'b1,1'b0,8'd21,4'h0, 16'hABCE,4'hC,1'b0, 1'b1,1'b1}
  };

  function automatic string tag(int i);
    case (i)
      0, 1:   return "R5 R9";
      2, 3:   return "R2 R3 R8";
      4, 7:   return "R4 R5 R7";
      5, 11:  return "R9 R8";
      6, 12:  return "R9 R3";
      8:      return "R3 R8";
      9:      return "R6 R5 R7";
      10:     return "R6 R7";
      default: return "R2 R3";
    endcase
  endfunction

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 a_rdata in reset", a_rdata, 16'h0);
    check("R1 b_rdata in reset", {12'h0, b_rdata}, 16'h0);
    check("R1 clash in reset", {15'h0, clash}, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      {a_en, a_we, a_addr, a_wdata, b_en, b_we, b_addr, b_wdata} = TBL[i][60:23];
      @(posedge clk);
      #1;
      if (TBL[i][1]) check($sformatf("row %0d %s a_rdata", i, tag(i)), a_rdata, TBL[i][22:7]);
      if (TBL[i][0]) check($sformatf("row %0d %s b_rdata", i, tag(i)), {12'h0, b_rdata}, {12'h0, TBL[i][6:3]});
      check($sformatf("row %0d %s clash", i, tag(i)), {15'h0, clash}, {15'h0, TBL[i][2]});
    end

    // R7: one-cycle pulse only, idle cycle follows
    @(negedge clk);
    a_en = 1'b1; a_we = 1'b0; a_addr = 6'd5; b_en = 1'b1; b_we = 1'b1; b_addr = 8'd22; b_wdata = 4'h6;
    @(posedge clk); #1;
    check("R7 clash on B write into A word", {15'h0, clash}, 16'h1);
    @(negedge clk);
    a_en = 1'b0; b_en = 1'b0;
    @(posedge clk); #1;
    check("R7 clash drops after one cycle", {15'h0, clash}, 16'h0);
    check("R9 a_rdata held while disabled", a_rdata, 16'hABCE);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 a_rdata cleared by reset", a_rdata, 16'h0);
    check("R1 b_rdata cleared by reset", {12'h0, b_rdata}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    a_en = 1'b1; a_addr = 6'd5; b_en = 1'b1; b_we = 1'b0; b_addr = 8'd22;
    @(posedge clk); #1;
    check("R3 word 5 after nibble 2 write", a_rdata, 16'hA6CE);
    check("R3 nibble 2 of word 5", {12'h0, b_rdata}, 16'h6);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule